// File: doc/BRIEF.md
# Triple-Buffer Role Rotation Controller

This block keeps three equal sample buffers and moves each one through three jobs. One buffer collects the incoming stream, one belongs to an external processing engine, and one plays back to the outgoing stream. The incoming and outgoing streams share one sample rate, nominally 100,000 samples per second. Each accepted input sample is written at the current fill index. In the same cycle, the output buffer is read at that same index, so playback runs in lockstep with capture.

When the fill index wraps, the three buffers swap jobs. The freshly filled buffer goes to the engine. The buffer the engine just finished goes to playback. The buffer that has been played out goes back to collecting. At each swap the engine gets a one-cycle start pulse along with the number of the buffer it now owns. It works on that buffer through a private read/write port and answers with a done pulse. A sticky flag records any swap that arrives before the engine has answered. Buffer depth is a parameter: a full deployment uses 10,000 samples per buffer, while the default stays small.

Top module: `tribuf_rotator`

## Requirements
- R1: While reset is asserted and right after it, `out_valid_o`, `proc_start_o` and `overrun_o` are 0 and `proc_sel_o` is 2. Buffer 0 is the first to fill and buffer 1 is the first to play back.
- R2: Every accepted input sample (`in_valid_i` high) is stored at the fill index. The index advances by one per sample and wraps from DEPTH-1 to 0. No job swap happens before the DEPTH-th sample after reset.
- R3: The jobs swap on the clock edge that accepts the sample at index DEPTH-1. After the swap, `proc_sel_o` names the buffer just filled, so across successive swaps it reads 0, 1, 2, 0, and so on. Between swaps it holds steady.
- R4: Each accepted input sample produces `out_valid_o` high on the following cycle. That output carries the playback buffer's word at the same index the input was written to.
- R5: Until two swaps have completed since reset, every output sample is 0, whatever the buffer memories hold.
- R6: `proc_start_o` is high for exactly one cycle after each swap. Once the first swap has happened, it pulses once every DEPTH input samples.
- R7: The engine port reads and writes only the buffer named by `proc_sel_o`, with one cycle of read latency. Buffer contents the engine does not write pass to playback unchanged.
- R8: If a swap occurs while the engine has not pulsed `proc_done_i` since the previous start, `overrun_o` is set. It then stays set until reset.
- R9: With an engine that rewrites each word as its value plus one, output sample n (counted from reset) equals input sample n-2*DEPTH plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | DATA_W | Input sample |
| out_valid_o | output | 1 | Output sample strobe, one cycle after input strobe |
| out_data_o | output | DATA_W | Output sample, 0 until primed |
| proc_start_o | output | 1 | One-cycle start pulse to the engine |
| proc_sel_o | output | 2 | Buffer currently owned by the engine |
| proc_done_i | input | 1 | Engine completion pulse |
| proc_addr_i | input | IDX_W | Engine word address |
| proc_we_i | input | 1 | Engine write enable |
| proc_wdata_i | input | DATA_W | Engine write data |
| proc_rdata_o | output | DATA_W | Engine read data, one cycle latency |
| overrun_o | output | 1 | Sticky late-engine flag |

## Verification
The overrun condition is the hardest case to reach. It needs a swap that lands while the engine still owes a done pulse, and a well-behaved engine never allows that. The bench therefore runs a behavioural engine that can be switched off. It disables the engine after a fresh reset and checks that the flag stays clear at the first swap, turns on at the second, and stays on after the engine is re-enabled. That same run after reset finds earlier data still sitting in the memories. This shows that the zero gating on the output, and not the memory contents, keeps the first two fills silent.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam int unsigned NUM_BUF = 3;
  typedef logic [1:0] buf_id_t;
  // initial job assignment
  localparam buf_id_t FILL_RST  = 2'd0;
  localparam buf_id_t DRAIN_RST = 2'd1;
  localparam buf_id_t PROC_RST  = 2'd2;
endpackage

// File: rtl/tribuf_mem.sv
module tribuf_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1000,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/tribuf_ctrl.sv
module tribuf_ctrl
  import tribuf_pkg::*;
#(
  parameter int unsigned DEPTH = 1000,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             done_i,
  output logic [IDX_W-1:0] idx_o,
  output buf_id_t          fill_sel_o,
  output buf_id_t          proc_sel_o,
  output buf_id_t          drain_sel_o,
  output logic             primed_o,
  output logic             start_o,
  output logic             overrun_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  buf_id_t          fill_q, proc_q, drain_q;
  logic [1:0]       rot_cnt_q;
  logic             start_q, busy_q, overrun_q;
  logic             wrap;

  assign wrap = in_valid_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (in_valid_i) begin
      idx_q <= wrap ? '0 : idx_q + 1'b1;
    end
  end

  // job rotation: filled -> engine, engine -> playback, playback -> fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q    <= FILL_RST;
      proc_q    <= PROC_RST;
      drain_q   <= DRAIN_RST;
      rot_cnt_q <= '0;
    end else if (wrap) begin
      fill_q    <= drain_q;
      proc_q    <= fill_q;
      drain_q   <= proc_q;
      if (rot_cnt_q != 2'd2) rot_cnt_q <= rot_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= 1'b0;
      busy_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      start_q <= wrap;
      if (wrap && busy_q && !done_i) overrun_q <= 1'b1;
      if (wrap)        busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign idx_o       = idx_q;
  assign fill_sel_o  = fill_q;
  assign proc_sel_o  = proc_q;
  assign drain_sel_o = drain_q;
  assign primed_o    = (rot_cnt_q == 2'd2);
  assign start_o     = start_q;
  assign overrun_o   = overrun_q;

  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);

  // R3
  role_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(proc_q) && $stable(fill_q) && $stable(drain_q));

  // R3
  roles_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q != proc_q) && (proc_q != drain_q) && (fill_q != drain_q));

  // R6
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q |=> overrun_q);
endmodule

// File: rtl/tribuf_rotator.sv
module tribuf_rotator
  import tribuf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1000,
  parameter int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              proc_start_o,
  output logic [1:0]        proc_sel_o,
  input  logic              proc_done_i,
  input  logic [IDX_W-1:0]  proc_addr_i,
  input  logic              proc_we_i,
  input  logic [DATA_W-1:0] proc_wdata_i,
  output logic [DATA_W-1:0] proc_rdata_o,
  output logic              overrun_o
);
  logic [IDX_W-1:0]  idx;
  buf_id_t           fill_sel, proc_sel, drain_sel;
  logic              primed;
  logic [DATA_W-1:0] rdata [NUM_BUF];

  tribuf_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .done_i     (proc_done_i),
    .idx_o      (idx),
    .fill_sel_o (fill_sel),
    .proc_sel_o (proc_sel),
    .drain_sel_o(drain_sel),
    .primed_o   (primed),
    .start_o    (proc_start_o),
    .overrun_o  (overrun_o)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    localparam buf_id_t ID = buf_id_t'(b);
    logic              we;
    logic [IDX_W-1:0]  waddr, raddr;
    logic [DATA_W-1:0] wdata;

    always_comb begin
      if (fill_sel == ID) begin
        we = in_valid_i; waddr = idx; wdata = in_data_i;
      end else if (proc_sel == ID) begin
        we = proc_we_i; waddr = proc_addr_i; wdata = proc_wdata_i;
      end else begin
        we = 1'b0; waddr = proc_addr_i; wdata = proc_wdata_i;
      end
      raddr = (drain_sel == ID) ? idx : proc_addr_i;
    end

    tribuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
      .clk_i  (clk_i),
      .we_i   (we),
      .waddr_i(waddr),
      .wdata_i(wdata),
      .raddr_i(raddr),
      .rdata_o(rdata[b])
    );
  end

  // selects captured alongside the synchronous read
  logic    out_valid_q, gate_q;
  buf_id_t drain_rd_q, proc_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      gate_q      <= 1'b0;
      drain_rd_q  <= DRAIN_RST;
      proc_rd_q   <= PROC_RST;
    end else begin
      out_valid_q <= in_valid_i;
      proc_rd_q   <= proc_sel;
      if (in_valid_i) begin
        gate_q     <= primed;
        drain_rd_q <= drain_sel;
      end
    end
  end

  function automatic logic [DATA_W-1:0] pick(input buf_id_t s,
                                              input logic [DATA_W-1:0] d0,
                                              input logic [DATA_W-1:0] d1,
                                              input logic [DATA_W-1:0] d2);
    case (s)
      2'd0:    return d0;
      2'd1:    return d1;
      default: return d2;
    endcase
  endfunction

  assign out_valid_o  = out_valid_q;
  assign out_data_o   = (out_valid_q && gate_q) ?
                        pick(drain_rd_q, rdata[0], rdata[1], rdata[2]) : '0;
  assign proc_rdata_o = pick(proc_rd_q, rdata[0], rdata[1], rdata[2]);
  assign proc_sel_o   = proc_sel;

  // R4
  out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R4
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o && (out_data_o == '0));
endmodule

// File: tb/sim_tribuf_rotator.sv
`timescale 1ns/1ps
module sim_tribuf_rotator;
  localparam int D = 4;
  localparam int W = 16;
  localparam int IW = 2;
  localparam int NV = 24;
  localparam logic [W-1:0] VEC [NV] = '{
    16'h0011, 16'h0a22, 16'h1033, 16'hfffe, 16'h0001, 16'h7f00, 16'h8000, 16'h1234,
    16'h5555, 16'haaaa, 16'h0f0f, 16'hf0f0, 16'h00ff, 16'hff00, 16'h3c3c, 16'hc3c3,
    16'h0100, 16'h0200, 16'h0400, 16'h0800, 16'hbeef, 16'hcafe, 16'h0042, 16'h7777};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid, proc_start, overrun, proc_done;
  logic [W-1:0] out_data, proc_rdata, proc_wdata;
  logic [1:0] proc_sel;
  logic [IW-1:0] proc_addr;
  logic proc_we;

  int checks = 0, failures = 0, start_cnt = 0;
  logic eng_en = 1'b1;
  logic sel_chk_en = 1'b1;
  logic start_prev = 1'b0;

  always #4 clk = ~clk;

  tribuf_rotator #(.DATA_W(W), .DEPTH(D), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .proc_start_o(proc_start),
    .proc_sel_o(proc_sel), .proc_done_i(proc_done), .proc_addr_i(proc_addr),
    .proc_we_i(proc_we), .proc_wdata_i(proc_wdata), .proc_rdata_o(proc_rdata),
    .overrun_o(overrun));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine model: each word becomes word+1
  initial begin
    proc_done = 1'b0; proc_addr = '0; proc_we = 1'b0; proc_wdata = '0;
    forever begin
      @(negedge clk);
      if (proc_start && eng_en) begin
        for (int i = 0; i < D; i++) begin
          proc_addr = IW'(i); proc_we = 1'b0;
          @(negedge clk);
          proc_wdata = proc_rdata + 1'b1; proc_we = 1'b1;
          @(negedge clk);
          proc_we = 1'b0;
        end
        proc_done = 1'b1;
        @(negedge clk);
        proc_done = 1'b0;
      end
    end
  end

  // start monitor: R3 job order, R6 pulse width
  always @(negedge clk) begin
    if (rst_n && proc_start) begin
      start_cnt++;
      chk("R6 start width", int'(start_prev), 0);
      if (sel_chk_en) chk("R3 proc_sel order", int'(proc_sel), (start_cnt - 1) % 3);
    end
    start_prev = proc_start;
  end

  task automatic send(input logic [W-1:0] d, input int exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 out_valid", int'(out_valid), 1);
    chk(req, int'(out_data), exp);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 proc_start", int'(proc_start), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 proc_sel", int'(proc_sel), 2);
    rst_n = 1'b1;
    start_cnt = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // vector walk: R5 zeros for two fills, R9 processed data after
    for (int n = 0; n < NV; n++) begin
      if (n < 2 * D) send(VEC[n], 0, "R5 zero before primed");
      else           send(VEC[n], int'(VEC[n - 2 * D] + 1'b1), "R9 processed out");
      chk("R2 starts vs samples", start_cnt, (n + 1) / D);
    end
    chk("R1 overrun after clean run", int'(overrun), 0);

    // reset with stale memory contents, engine disabled
    do_reset();
    eng_en = 1'b0;
    for (int n = 0; n < 3 * D; n++) begin
      if (n < 2 * D) send(W'(n + 100), 0, "R5 stale memory gated");
      else           send(W'(n + 100), n + 100 - 2 * D, "R7 unprocessed passthrough");
      if (n == D - 1)     chk("R8 no overrun first swap", int'(overrun), 0);
      if (n == 2 * D - 1) chk("R8 overrun set", int'(overrun), 1);
      if (n == 2 * D)     eng_en = 1'b1;
    end
    repeat (20) @(negedge clk);
    chk("R8 overrun sticky", int'(overrun), 1);
    chk("R6 one start per fill", start_cnt, 3);
    // R3 hold: no input, no swap
    sel_chk_en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 proc_sel hold", int'(proc_sel), 2);
    chk("R4 idle out_valid", int'(out_valid), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule